// File: doc/BRIEF.md
# Windowed Watchdog Timer with Control Lock

This block is a watchdog timer behind a small 32-bit register interface. A counter advances on each cycle in which the watchdog clock-enable input is high, but only while software has enabled both the timer and its clock. Software keeps the watchdog quiet by writing a two-byte key, in order, to the feed register. Each correct feed restarts the count from zero.

If the count reaches the programmed interrupt interval, a timeout flag is raised. If it reaches the longer reset interval, a reset flag is raised and a single-cycle reset request leaves the block. A feed that arrives before a programmed wait window has closed is treated as suspicious and raises its own early-feed flag. All three intervals are powers of two, selected by 4-bit codes.

The control register can be frozen with a lock key and released with an unlock key. This guards the intervals and the run bits against stray writes. The flags are sticky and are cleared by writing 1 to them. A single interrupt line combines each flag with its own enable bit.

Top module: `win_watchdog`

## Requirements
- R1: After reset the block reads as follows: control reads 0 (all codes 0, timer and clock off), lock reads 0, flags read 0, enables read 0, and `irq` and `rst_req` are low.
- R2: The counter advances only in a cycle where control bit 8 (timer on), control bit 9 (clock on) and `wd_tick` are all 1. If any of them is 0, no interval can expire.
- R3: Flag bit 0 (timeout) becomes 1 on the Nth advancing cycle after a restart. N is 2^(TOP_EXP - code), and the code is control bits [3:0].
- R4: Flag bit 2 (reset) becomes 1 in the same way, using control bits [7:4] as the code. When enable bit 2 is set, `rst_req` is high for exactly one cycle, on the cycle that flag bit 2 is raised.
- R5: Flag bit 1 (early feed) becomes 1 when a feed completes while fewer than 2^(TOP_EXP - code) cycles have been counted since the last restart. Here the code is control bits [15:12].
- R6: Writing 0xA5 and then 0x5A in bits [7:0] of offset 0x04 completes a feed, which resets the count to 0.
- R7: At offset 0x04, any byte other than 0xA5 or 0x5A drops a pending 0xA5 back to idle. A 0x5A with no pending 0xA5 does nothing. Neither case restarts the count.
- R8: At offset 0x14, writing 0x24 in bits [7:0] locks the block and writing 0x42 unlocks it. Any other value is ignored. The lock register reads 1 in bit 0 while locked. While locked, writes to the control register (offset 0x00) have no effect.
- R9: Flags at offset 0x08 are sticky. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R10: `irq` is high whenever any flag bit is set together with the matching enable bit at offset 0x0C (bit 0 timeout, bit 1 early feed, bit 2 reset).
- R11: Offset 0x10 always reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_tick | input | 1 | Watchdog clock enable; one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined, enable-gated flag interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Random trials draw the interval codes, the enable mask, the gap between two feeds and the wait after a feed. The bench computes the expected flags from the cycle count in each trial. This separates an off-by-one expiry from a correct one, and an early feed from a timely one. Directed sequences cover several further cases:
- Each run-gating input is held low on its own, which shows that every one of them stalls the count.
- Malformed feed keys are sent, each followed by a valid feed. Whether that valid feed is flagged as early shows whether the count was restarted.
- Lock and unlock keys are mixed with junk lock values.
- Flags are cleared one bit at a time to expose sticky behaviour.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

   // word indices of the register slots (byte offset >> 2)
   localparam logic [7:0] IDX_CTRL  = 8'd0;
   localparam logic [7:0] IDX_FEED  = 8'd1;
   localparam logic [7:0] IDX_FLAG  = 8'd2;
   localparam logic [7:0] IDX_IRQEN = 8'd3;
   localparam logic [7:0] IDX_LOCK  = 8'd5;

   // keys
   localparam logic [7:0] KEY_ARM    = 8'hA5;
   localparam logic [7:0] KEY_FIRE   = 8'h5A;
   localparam logic [7:0] KEY_LOCK   = 8'h24;
   localparam logic [7:0] KEY_UNLOCK = 8'h42;

   // flag / enable bit positions
   localparam int FB_TMO   = 0;
   localparam int FB_EARLY = 1;
   localparam int FB_RST   = 2;
   localparam int NFLAG    = 3;

   typedef struct packed {
      logic [3:0] win_code;
      logic [1:0] spare;
      logic       clk_on;
      logic       tmr_on;
      logic [3:0] rst_code;
      logic [3:0] int_code;
   } ctl_t;

endpackage

// File: rtl/wwdg_feed_seq.sv
module wwdg_feed_seq
   import wwdg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb_i,
   input  logic [7:0] wbyte_i,
   output logic       feed_o
);

   logic armed_q;

   assign feed_o = wr_stb_i && armed_q && (wbyte_i == KEY_FIRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (wr_stb_i) armed_q <= (wbyte_i == KEY_ARM);
   end

endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          tick_i,
   input  logic          restart_i,
   output logic [CW-1:0] cnt_o,
   output logic          step_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;

   assign step_o = run_i && tick_i && !restart_i && (cnt_q != '1);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (step_o)    cnt_q <= cnt_q + ONE;
   end

endmodule

// File: rtl/wwdg_expiry.sv
module wwdg_expiry #(
   parameter int TOP_EXP = 31,
   parameter int CW      = 32,
   parameter bit BELOW   = 1'b0
) (
   input  logic [3:0]    code_i,
   input  logic [CW-1:0] cnt_i,
   output logic          fire_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] span;
   assign span = ONE << (TOP_EXP - int'(code_i));

   generate
      if (BELOW) begin : g_window
         assign fire_o = (cnt_i < span);
      end else begin : g_reach
         assign fire_o = (cnt_i == span - ONE);
      end
   endgenerate

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
   import wwdg_pkg::*;
#(
   parameter int TOP_EXP = 31,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              rst_req
);

   localparam int CW = TOP_EXP + 1;
   localparam int IW = ADDR_W - 2;

   generate
      if (TOP_EXP < 15 || TOP_EXP > 62) begin : g_bad_exp
         $error("win_watchdog: TOP_EXP must lie in 15..62");
      end
      if (ADDR_W < 5 || ADDR_W > 10) begin : g_bad_addr
         $error("win_watchdog: ADDR_W must lie in 5..10");
      end
   endgenerate

   logic [IW-1:0]    widx;
   logic             wr_ctrl, wr_feed, wr_flag, wr_en, wr_lock;
   ctl_t             ctrl_q;
   logic             lock_q;
   logic [NFLAG-1:0] en_q, flags_q, evt, fire;
   logic [3:0]       codes [NFLAG];
   logic [CW-1:0]    cnt_q;
   logic             step, feed, run;
   logic             unused_bits;

   assign widx    = reg_addr[ADDR_W-1:2];
   assign wr_ctrl = reg_wr && (8'(widx) == IDX_CTRL);
   assign wr_feed = reg_wr && (8'(widx) == IDX_FEED);
   assign wr_flag = reg_wr && (8'(widx) == IDX_FLAG);
   assign wr_en   = reg_wr && (8'(widx) == IDX_IRQEN);
   assign wr_lock = reg_wr && (8'(widx) == IDX_LOCK);
   assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:16], reg_wdata[11:10]};

   // control, lock and enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         lock_q <= 1'b0;
         en_q   <= '0;
      end else begin
         if (wr_ctrl && !lock_q) begin
            ctrl_q.win_code <= reg_wdata[15:12];
            ctrl_q.spare    <= 2'b00;
            ctrl_q.clk_on   <= reg_wdata[9];
            ctrl_q.tmr_on   <= reg_wdata[8];
            ctrl_q.rst_code <= reg_wdata[7:4];
            ctrl_q.int_code <= reg_wdata[3:0];
         end
         if (wr_lock) begin
            if (reg_wdata[7:0] == KEY_LOCK)        lock_q <= 1'b1;
            else if (reg_wdata[7:0] == KEY_UNLOCK) lock_q <= 1'b0;
         end
         if (wr_en) en_q <= reg_wdata[NFLAG-1:0];
      end
   end

   assign run = ctrl_q.tmr_on && ctrl_q.clk_on;

   wwdg_feed_seq u_feed (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb_i (wr_feed),
      .wbyte_i  (reg_wdata[7:0]),
      .feed_o   (feed)
   );

   wwdg_counter #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .tick_i    (wd_tick),
      .restart_i (feed),
      .cnt_o     (cnt_q),
      .step_o    (step)
   );

   assign codes[FB_TMO]   = ctrl_q.int_code;
   assign codes[FB_EARLY] = ctrl_q.win_code;
   assign codes[FB_RST]   = ctrl_q.rst_code;

   // one comparator and one sticky flag per event kind
   generate
      for (genvar g = 0; g < NFLAG; g++) begin : g_evt
         wwdg_expiry #(
            .TOP_EXP (TOP_EXP),
            .CW      (CW),
            .BELOW   (g == FB_EARLY)
         ) u_exp (
            .code_i (codes[g]),
            .cnt_i  (cnt_q),
            .fire_o (fire[g])
         );

         if (g == FB_EARLY) begin : g_on_feed
            assign evt[g] = feed && fire[g];
         end else begin : g_on_step
            assign evt[g] = step && fire[g];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[g] <= 1'b0;
            else        flags_q[g] <= evt[g] || (flags_q[g] && !(wr_flag && reg_wdata[g]));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= evt[FB_RST] && en_q[FB_RST];
   end

   assign irq = |(flags_q & en_q);

   always_comb begin
      reg_rdata = '0;
      case (8'(widx))
         IDX_CTRL:  reg_rdata[15:0]      = ctrl_q;
         IDX_FLAG:  reg_rdata[NFLAG-1:0] = flags_q;
         IDX_IRQEN: reg_rdata[NFLAG-1:0] = en_q;
         IDX_LOCK:  reg_rdata[0]         = lock_q;
         default:   reg_rdata            = '0;
      endcase
   end

endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker
   import wwdg_pkg::*;
#(
   parameter int CW = 32,
   parameter int IW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [IW-1:0] widx,
   input logic [15:0]   ctrl_q,
   input logic          lock_q,
   input logic [2:0]    flags_q,
   input logic [2:0]    en_q,
   input logic [CW-1:0] cnt_q,
   input logic          feed,
   input logic          run,
   input logic          rst_req
);

   logic flag_wr;
   assign flag_wr = reg_wr && (8'(widx) == IDX_FLAG);

   assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !feed) |=> $stable(cnt_q));

   assert_feed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      feed |=> (cnt_q == '0));

   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_pulse_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (flags_q[FB_RST] && en_q[FB_RST]));

   assert_locked_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && reg_wr && (8'(widx) == IDX_CTRL)) |=> $stable(ctrl_q));

   assert_sticky_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

bind win_watchdog wwdg_checker #(.CW(CW), .IW(IW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .widx    (widx),
   .ctrl_q  (ctrl_q),
   .lock_q  (lock_q),
   .flags_q (flags_q),
   .en_q    (en_q),
   .cnt_q   (cnt_q),
   .feed    (feed),
   .run     (run),
   .rst_req (rst_req)
);

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TOP_EXP    = 17;
   localparam logic [4:0] A_CTRL = 5'h00, A_FEED = 5'h04, A_FLAG = 5'h08,
                          A_EN = 5'h0C, A_RSVD = 5'h10, A_LOCK = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n, wd_tick, reg_wr;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        irq, rst_req;

   int n_chk = 0, n_err = 0, pulses = 0;
   logic [31:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(negedge clk) if (rst_req) pulses = pulses + 1;

   win_watchdog #(.TOP_EXP(TOP_EXP), .ADDR_W(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .rst_req(rst_req)
   );

   function automatic int span(input int code);
      return 1 << (TOP_EXP - code);
   endfunction

   function automatic logic [31:0] mk_ctrl(input int ic, input int rc, input int wc);
      return (32'(wc) << 12) | 32'h300 | (32'(rc) << 4) | 32'(ic);
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic feed();
      wr(A_FEED, 32'hA5); wr(A_FEED, 32'h5A);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wd_tick = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_LOCK, v); check("R1 lock", v, 0);
      rd(A_FLAG, v); check("R1 flags", v, 0);
      rd(A_EN, v);   check("R1 enable", v, 0);
      check("R1 irq/rst_req", {30'd0, irq, rst_req}, 0);

      // R11 reserved slot
      wr(A_RSVD, 32'hFFFF_FFFF);
      rd(A_RSVD, v); check("R11 reserved reads zero", v, 0);
      rd(A_EN, v);   check("R11 write had no effect", v, 0);

      // R2 run gating: each gate off on its own
      wr(A_CTRL, 32'h00FF & ~32'h300 | 32'h0FF);
      feed(); wr(A_FLAG, 7); waitn(20);
      rd(A_FLAG, v); check("R2 timer and clock off", v, 0);
      wr(A_CTRL, 32'h01FF);
      waitn(20); rd(A_FLAG, v); check("R2 clock off", v, 0);
      wr(A_CTRL, 32'h02FF);
      waitn(20); rd(A_FLAG, v); check("R2 timer off", v, 0);
      wd_tick = 1'b0;
      wr(A_CTRL, 32'h03FF);
      waitn(20); rd(A_FLAG, v); check("R2 tick low", v, 0);
      wd_tick = 1'b1;
      waitn(20); rd(A_FLAG, v); check("R2 all gates on", v, 32'h5);

      // R3 / R4 directed boundaries: int 8, reset 32
      wr(A_CTRL, mk_ctrl(14, 12, 15));
      wr(A_EN, 7);
      feed(); wr(A_FLAG, 7); pulses = 0;
      waitn(6); rd(A_FLAG, v); check("R3 one before interval", v & 1, 0);
      waitn(1); rd(A_FLAG, v); check("R3 interval reached", v & 1, 1);
      check("R10 irq with timeout enabled", 32'(irq), 1);
      waitn(23); rd(A_FLAG, v); check("R4 one before reset interval", v & 4, 0);
      check("R4 no pulse yet", pulses, 0);
      waitn(1); rd(A_FLAG, v); check("R4 reset interval reached", v & 4, 4);
      @(negedge clk); #1;
      check("R4 single pulse", pulses, 1);
      waitn(10); check("R4 pulse not repeated", pulses, 1);

      // random trials
      for (int t = 0; t < 40; t++) begin
         int ic, rc, wc, j, k;
         logic [2:0] em, fe;
         ic = $urandom_range(15, 13); rc = $urandom_range(15, 11);
         wc = $urandom_range(15, 11); em = 3'($urandom_range(7, 0));
         j  = $urandom_range(70, 0);  k  = $urandom_range(80, 1);
         wr(A_CTRL, mk_ctrl(ic, rc, wc));
         wr(A_EN, 32'(em));
         feed(); wr(A_FLAG, 7);
         waitn(j);
         feed();
         rd(A_FLAG, v);
         check("R5 early-feed flag", (v >> 1) & 1, 32'(j + 2 < span(wc)));
         wr(A_FLAG, 7); pulses = 0;
         waitn(k);
         fe = {1'(1 + k >= span(rc)), 1'b0, 1'(1 + k >= span(ic))};
         rd(A_FLAG, v);
         check("R3/R4 random flags", v, 32'(fe));
         check("R10 random irq", 32'(irq), 32'(|(fe & em)));
         @(negedge clk); #1;
         check("R4 random pulse count", pulses, 32'(fe[2] && em[2]));
      end

      // R6 / R7 feed sequence
      wr(A_EN, 0);
      wr(A_CTRL, mk_ctrl(15, 15, 12));
      feed(); wr(A_FLAG, 7); waitn(100);
      wr(A_FEED, 32'hA5); wr(A_FEED, 32'h11); wr(A_FEED, 32'h5A);
      rd(A_FLAG, v); check("R7 broken key is no feed", v & 2, 0);
      wr(A_FEED, 32'h5A);
      rd(A_FLAG, v); check("R7 lone second key is no feed", v & 2, 0);
      feed();
      rd(A_FLAG, v); check("R7 count kept (late feed)", v & 2, 0);
      feed();
      rd(A_FLAG, v); check("R6 feed restarted count", v & 2, 2);

      // R8 lock
      wr(A_LOCK, 32'h24);
      rd(A_LOCK, v); check("R8 locked readback", v, 1);
      wr(A_CTRL, 32'h0123);
      rd(A_CTRL, v); check("R8 ctrl frozen", v, mk_ctrl(15, 15, 12));
      wr(A_LOCK, 32'h77);
      rd(A_LOCK, v); check("R8 junk lock value ignored", v, 1);
      wr(A_LOCK, 32'h42);
      rd(A_LOCK, v); check("R8 unlocked readback", v, 0);
      wr(A_CTRL, 32'h0123);
      rd(A_CTRL, v); check("R8 ctrl writable again", v, 32'h0123);

      // R9 sticky W1C
      wr(A_CTRL, mk_ctrl(15, 15, 15));
      feed(); wr(A_FLAG, 7); waitn(10);
      rd(A_FLAG, v); check("R9 both flags up", v, 5);
      wr(A_FLAG, 1);
      rd(A_FLAG, v); check("R9 partial clear", v, 4);
      waitn(5);
      rd(A_FLAG, v); check("R9 flag stays set", v, 4);
      wr(A_FLAG, 4);
      rd(A_FLAG, v); check("R9 clear remaining", v, 0);

      // R10 irq gating
      feed(); wr(A_FLAG, 7); waitn(10);
      wr(A_EN, 0); check("R10 irq masked", 32'(irq), 0);
      wr(A_EN, 1); check("R10 irq timeout", 32'(irq), 1);
      wr(A_EN, 2); check("R10 irq early only", 32'(irq), 0);
      wr(A_EN, 4); check("R10 irq reset", 32'(irq), 1);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule